// File: doc/BRIEF.md
# Bus-to-Register Clock-Crossing Bridge

This block takes single memory-mapped transfers issued by a processor in one clock domain and replays them as a plain register interface in an unrelated user clock domain. A bus master presents a word address with either a write strobe (plus data and byte enables) or a read strobe. The bridge holds the master off with a waitrequest until the transfer has finished on the far side. For a read, it returns the data with a one-cycle read-data-valid pulse.

On the user side, a write shows up as a one-cycle write enable carrying the address, data and byte enables. A read shows up as a one-cycle read request. The address then stays put until the register logic answers with a read-valid pulse, which may come after any number of cycles. Only one transfer is in flight at any time. The request crosses into the user domain as a toggle through a two-flop synchroniser, and a returning toggle carries the acknowledge back. The captured fields stay frozen in holding registers while the handshake runs.

Top module: `mm_reg_bridge`

## Requirements
- R1: After either reset, bus_wait is low while no strobe is present, and bus_rvalid, reg_wen and reg_rreq are all low.
- R2: Each bus write produces exactly one reg_wen pulse lasting one user cycle. During that pulse, reg_addr, reg_wdata and reg_be equal the values on the bus. Bit n of reg_be qualifies reg_wdata bits 8n+7 to 8n and is passed on unchanged.
- R3: Each bus read produces exactly one reg_rreq pulse lasting one user cycle, with reg_addr equal to the bus address. reg_addr keeps that value until reg_rvalid is sampled high.
- R4: A read completes with bus_rvalid high for exactly one CPU cycle. That cycle is the one in which bus_wait is low, and bus_rdata then equals the reg_rdata value that was present with reg_rvalid.
- R5: bus_wait is high from the first cycle a strobe is presented until the transfer completes. It is then low for the single completing cycle.
- R6: A write completes with bus_wait low and bus_rvalid low.
- R7: The read response may arrive any number of user cycles after reg_rreq, including the same cycle in which reg_rreq is high.
- R8: When bus_wr and bus_rd are both high, the transfer is carried out as a write and no read request is issued.
- R9: A reg_rvalid pulse with no read pending is ignored: it produces no bus_rvalid, and the next read still returns its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Bus-side clock |
| cpu_rst_n | input | 1 | Bus-side asynchronous reset, active low |
| bus_addr | input | ADDR_W | Word address of the transfer |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Write byte enables |
| bus_wait | output | 1 | Waitrequest; the master holds the transfer while this is high |
| bus_rdata | output | DATA_W | Read data |
| bus_rvalid | output | 1 | Read data valid pulse |
| usr_clk | input | 1 | Register-side clock |
| usr_rst_n | input | 1 | Register-side asynchronous reset, active low |
| reg_wen | output | 1 | Register write enable pulse |
| reg_addr | output | ADDR_W | Register word address |
| reg_wdata | output | DATA_W | Register write data |
| reg_be | output | DATA_W/8 | Register byte enables |
| reg_rreq | output | 1 | Register read request pulse |
| reg_rvalid | input | 1 | Register read data valid |
| reg_rdata | input | DATA_W | Register read data |

## Verification
Writes are driven with single-byte, split-byte, full and empty byte-enable masks at both ends of the address range. This shows whether each field is passed on intact and whether exactly one write pulse goes out per transfer. Reads are answered after delays from zero to many cycles, and the bench checks that the address is held throughout and that the returned word is address-dependent. This separates correct hold-until-valid behaviour from a fixed-latency assumption. Two further cases are covered: a transfer with both strobes raised, which must become a write, and an unsolicited read-valid pulse, which must leave the bus side untouched.

// File: rtl/mm_reg_bridge.sv
module mm_reg_bridge #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              cpu_clk,
  input  logic              cpu_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  output logic              bus_wait,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              usr_clk,
  input  logic              usr_rst_n,
  output logic              reg_wen,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [BE_W-1:0]   reg_be,
  output logic              reg_rreq,
  input  logic              reg_rvalid,
  input  logic [DATA_W-1:0] reg_rdata
);

  // CPU domain
  logic              busy, fin, h_wr, req_tgl;
  logic              ack_s1, ack_s2, ack_seen;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic [BE_W-1:0]   h_be;

  // user domain
  logic              req_s1, req_s2, req_seen, pending, ack_tgl;
  logic [DATA_W-1:0] u_rdata;

  wire bus_req = bus_wr | bus_rd;
  wire ack_new = ack_s2 ^ ack_seen;
  wire req_new = req_s2 ^ req_seen;

  assign bus_wait = bus_req & ~fin;

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      busy       <= 1'b0;
      fin        <= 1'b0;
      h_wr       <= 1'b0;
      req_tgl    <= 1'b0;
      ack_s1     <= 1'b0;
      ack_s2     <= 1'b0;
      ack_seen   <= 1'b0;
      h_addr     <= '0;
      h_wdata    <= '0;
      h_be       <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      ack_s1     <= ack_tgl;
      ack_s2     <= ack_s1;
      fin        <= 1'b0;
      bus_rvalid <= 1'b0;
      if (!busy && bus_req) begin
        busy    <= 1'b1;
        req_tgl <= ~req_tgl;
        h_wr    <= bus_wr;
        h_addr  <= bus_addr;
        h_wdata <= bus_wdata;
        h_be    <= bus_be;
      end else if (fin) begin
        busy <= 1'b0;
      end else if (busy && ack_new) begin
        ack_seen   <= ack_s2;
        fin        <= 1'b1;
        bus_rvalid <= ~h_wr;
        bus_rdata  <= u_rdata;
      end
    end
  end

  always_ff @(posedge usr_clk or negedge usr_rst_n) begin
    if (!usr_rst_n) begin
      req_s1    <= 1'b0;
      req_s2    <= 1'b0;
      req_seen  <= 1'b0;
      pending   <= 1'b0;
      ack_tgl   <= 1'b0;
      reg_wen   <= 1'b0;
      reg_rreq  <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_be    <= '0;
      u_rdata   <= '0;
    end else begin
      req_s1   <= req_tgl;
      req_s2   <= req_s1;
      reg_wen  <= 1'b0;
      reg_rreq <= 1'b0;
      if (req_new && !pending) begin
        req_seen  <= req_s2;
        reg_addr  <= h_addr;
        reg_wdata <= h_wdata;
        reg_be    <= h_be;
        if (h_wr) begin
          reg_wen <= 1'b1;
          ack_tgl <= ~ack_tgl;
        end else begin
          reg_rreq <= 1'b1;
          pending  <= 1'b1;
        end
      end else if (pending && reg_rvalid) begin
        u_rdata <= reg_rdata;
        pending <= 1'b0;
        ack_tgl <= ~ack_tgl;
      end
    end
  end

  AST_WEN_PULSE: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    reg_wen |=> !reg_wen); // R2
  AST_RREQ_PULSE: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    reg_rreq |=> !reg_rreq); // R3
  AST_ADDR_HELD: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    (pending && !reg_rvalid) |=> $stable(reg_addr)); // R3
  AST_NO_WEN_ON_READ: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    !(reg_wen && reg_rreq)); // R8
  AST_RVALID_PULSE: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    bus_rvalid |=> !bus_rvalid); // R4
  AST_RVALID_WITH_DONE: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    bus_rvalid |-> (bus_req && !bus_wait)); // R4
  AST_WAIT_IDLE: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    !bus_req |-> !bus_wait); // R1

endmodule

// File: tb/tb_mm_reg_bridge.sv
`timescale 1ns/1ps
module tb_mm_reg_bridge;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int VW = 2 + AW + DW + BW + 8;
  localparam int NV = 10;

  // {wr, rd, addr, data, be, read delay}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b0, 12'h000, 32'h1122_3344, 4'b1111, 8'd0},
    {1'b1, 1'b0, 12'hFFF, 32'hDEAD_BEEF, 4'b0001, 8'd0},
    {1'b1, 1'b0, 12'h5A5, 32'hCAFE_F00D, 4'b1000, 8'd0},
    {1'b1, 1'b0, 12'h0F0, 32'h0000_FFFF, 4'b0110, 8'd0},
    {1'b1, 1'b0, 12'h123, 32'hFFFF_0000, 4'b0000, 8'd0},
    {1'b0, 1'b1, 12'h000, 32'h0,         4'b0000, 8'd0},
    {1'b0, 1'b1, 12'hFFF, 32'h0,         4'b0000, 8'd1},
    {1'b0, 1'b1, 12'h3C3, 32'h0,         4'b0000, 8'd5},
    {1'b0, 1'b1, 12'hA0A, 32'h0,         4'b0000, 8'd17},
    {1'b1, 1'b1, 12'h777, 32'h7654_3210, 4'b1010, 8'd3}
  };

  logic cpu_clk = 0, usr_clk = 0, cpu_rst_n = 0, usr_rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [DW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_be = '0;
  logic bus_wait, bus_rvalid;
  logic [DW-1:0] bus_rdata;
  logic reg_wen, reg_rreq;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [BW-1:0] reg_be;
  logic reg_rvalid = 0;
  logic [DW-1:0] reg_rdata = '0;

  always #2.5 cpu_clk = ~cpu_clk;
  always #3.5 usr_clk = ~usr_clk;

  mm_reg_bridge #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_wait(bus_wait),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .usr_clk(usr_clk),
    .usr_rst_n(usr_rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rreq(reg_rreq),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata));

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] resp(input logic [AW-1:0] a);
    return {a, 8'h3C, a};
  endfunction

  // register-side responder
  int wen_cnt = 0, rreq_cnt = 0, rd_delay = 0;
  logic [AW-1:0] w_addr, r_addr;
  logic [DW-1:0] w_data;
  logic [BW-1:0] w_be;
  bit stray_go = 0;

  initial begin
    forever begin
      @(negedge usr_clk);
      if (reg_wen) begin
        wen_cnt++; w_addr = reg_addr; w_data = reg_wdata; w_be = reg_be;
      end
      if (stray_go) begin
        reg_rdata = 32'hBAD0_BAD0; reg_rvalid = 1;
        @(negedge usr_clk);
        reg_rvalid = 0; stray_go = 0;
      end else if (reg_rreq) begin
        rreq_cnt++; r_addr = reg_addr;
        for (int i = 0; i < rd_delay; i++) begin
          @(negedge usr_clk);
          chk(reg_addr == r_addr, "R3 address held", 64'(reg_addr), 64'(r_addr));
        end
        reg_rdata = resp(r_addr); reg_rvalid = 1;
        @(negedge usr_clk);
        reg_rvalid = 0; reg_rdata = 32'h0BAD_F00D;
      end
    end
  end

  task automatic xfer(input logic wr, input logic rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [BW-1:0] be, input int dly);
    int n, w0, r0;
    bit early_rv;
    logic rv;
    logic [DW-1:0] rdv;
    w0 = wen_cnt; r0 = rreq_cnt; early_rv = 0; n = 0;
    @(negedge cpu_clk);
    rd_delay = dly;
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d; bus_be = be;
    #0.5;
    chk(bus_wait == 1'b1, "R5 wait raised", 64'(bus_wait), 64'd1);
    forever begin
      @(negedge cpu_clk);
      n++;
      if (!bus_wait || n > 400) break;
      if (bus_rvalid) early_rv = 1;
    end
    chk(n <= 400, "R5 transfer completes", 64'(n), 64'd400);
    chk(!early_rv, "R4 no early rvalid", 64'(early_rv), 64'd0);
    rv = bus_rvalid; rdv = bus_rdata;
    @(posedge cpu_clk); #1;
    bus_wr = 0; bus_rd = 0;
    @(negedge cpu_clk);
    chk(!bus_rvalid && !bus_wait, "R4 rvalid single cycle", 64'(bus_rvalid), 64'd0);
    if (wr) begin
      chk(!rv, "R6 write gives no rvalid", 64'(rv), 64'd0);
      chk(wen_cnt == w0 + 1, rd ? "R8 both strobes write once" : "R2 one write pulse",
          64'(wen_cnt - w0), 64'd1);
      chk(rreq_cnt == r0, "R8 no read request on write", 64'(rreq_cnt - r0), 64'd0);
      chk(w_addr == a, "R2 address", 64'(w_addr), 64'(a));
      chk(w_data == d, "R2 data", 64'(w_data), 64'(d));
      chk(w_be == be, "R2 byte enables", 64'(w_be), 64'(be));
    end else begin
      chk(rreq_cnt == r0 + 1, "R3 one read request", 64'(rreq_cnt - r0), 64'd1);
      chk(r_addr == a, "R3 read address", 64'(r_addr), 64'(a));
      chk(rv, "R4 rvalid at completion", 64'(rv), 64'd1);
      chk(rdv == resp(a), "R7 read data after delay", 64'(rdv), 64'(resp(a)));
    end
  endtask

  initial begin
    repeat (3) @(negedge cpu_clk);
    cpu_rst_n = 1; usr_rst_n = 1;
    repeat (2) @(negedge cpu_clk);
    chk(!bus_wait && !bus_rvalid && !reg_wen && !reg_rreq, "R1 reset state",
        64'({bus_wait, bus_rvalid, reg_wen, reg_rreq}), 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      xfer(e[VW-1], e[VW-2], e[VW-3 -: AW], e[BW+8+DW-1 -: DW], e[8+BW-1 -: BW], int'(e[7:0]));
    end

    // R9: unsolicited read-valid is ignored
    begin
      bit seen = 0;
      stray_go = 1;
      for (int i = 0; i < 30; i++) begin
        @(negedge cpu_clk);
        if (bus_rvalid || bus_wait) seen = 1;
      end
      chk(!seen, "R9 stray rvalid ignored", 64'(seen), 64'd0);
      xfer(1'b0, 1'b1, 12'h456, '0, '0, 2);
    end

    // R7 long latency, then back-to-back writes (R2)
    xfer(1'b0, 1'b1, 12'h800, '0, '0, 60);
    xfer(1'b1, 1'b0, 12'h801, 32'hA5A5_5A5A, 4'b0101, 0);
    xfer(1'b1, 1'b0, 12'h802, 32'h5A5A_A5A5, 4'b1010, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule